// File: doc/BRIEF.md
# DDCMP Frame Receiver

This block turns an already-deframed byte stream into parsed message frames. Bytes arrive over a valid/ready interface. The receiver hunts for two consecutive sync octets. It then reads one class character that marks the frame as a data, control or maintenance message. Next it collects a fixed five-byte header and checks the header CRC that follows it.

For data and maintenance frames, the low bits of the first two header bytes give a byte count. This count is trusted only once the header CRC has matched. The receiver then passes exactly that many bytes downstream, with start and end markers, and checks a second CRC that covers the data field. Any byte value, including sync and class codes, is legal inside the data field, because the count alone ends the frame.

The header fields are presented with a one-cycle pulse. A status pulse then reports the frame class and two error flags. After that the receiver returns to hunting. Data bytes pass through without buffering. Downstream back-pressure stalls the input only while data bytes are being delivered.

Top module: `dmsg_rx`

## Requirements
- R1: After reset, `in_ready` is 1 and `hdr_valid`, `stat_valid` and `dout_valid` are 0 while no input is offered.
- R2: A frame is recognised only after two consecutive sync bytes (0x96). Further sync bytes before the class character are tolerated. A class byte preceded by fewer than two sync bytes produces no output.
- R3: The byte after sync is decoded as follows: 0x81 gives data class (code 1), 0x05 gives control class (code 2), 0x90 gives maintenance class (code 3). Any other byte other than sync returns the receiver to the hunt with no output.
- R4: Five header bytes follow the class byte and then two CRC bytes. When the header CRC matches, `hdr_valid` pulses for one cycle, starting the cycle after the second CRC byte is accepted. At that pulse `hdr_lead` = {second header byte, first header byte}, `hdr_mid0`/`hdr_mid1` are the third and fourth bytes, `hdr_addr` is the fifth byte and `hdr_class` is the class code.
- R5: Every CRC uses polynomial 0x1021, preset to zero, and feeds each byte MSB first. The header CRC covers the class byte and the five header bytes. It is received low byte first. On a mismatch, `stat_valid` pulses with `stat_hdr_err`=1 in the same cycle `hdr_valid` would have pulsed, `hdr_valid` stays 0, and no data is read.
- R6: For data and maintenance frames, exactly `hdr_lead[13:0]` bytes are passed out on `dout_data`. `dout_sop` marks the first of them and `dout_eop` marks the last. Bits 15:14 of `hdr_lead` do not change the length, and any byte value is passed as data.
- R7: A second CRC covers the data bytes only and is received low byte first after the last data byte. `stat_valid` pulses after its second byte, with `stat_data_err` set exactly when it mismatches.
- R8: A control frame has no data phase. Its status pulse coincides with `hdr_valid`, whatever its lead bytes hold.
- R9: A data or maintenance frame with a count of zero has no data phase and no data CRC. Its status pulse coincides with `hdr_valid`.
- R10: While data bytes are due, `in_ready` follows `dout_ready`. Everywhere else `in_ready` is 1 and `dout_valid` is 0.
- R11: After every status pulse the receiver hunts again, so frames can follow back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte offered |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| dout_valid | output | 1 | Data-field byte available |
| dout_data | output | 8 | Data-field byte |
| dout_sop | output | 1 | First byte of the data field |
| dout_eop | output | 1 | Last byte of the data field |
| dout_ready | input | 1 | Downstream accepts data byte |
| hdr_valid | output | 1 | Header fields valid (one cycle) |
| hdr_class | output | 2 | Frame class code |
| hdr_lead | output | 16 | First two header bytes, second byte high |
| hdr_mid0 | output | 8 | Third header byte |
| hdr_mid1 | output | 8 | Fourth header byte |
| hdr_addr | output | 8 | Fifth header byte (address) |
| stat_valid | output | 1 | Frame status valid (one cycle) |
| stat_class | output | 2 | Class of the finished frame |
| stat_hdr_err | output | 1 | Header CRC mismatch |
| stat_data_err | output | 1 | Data CRC mismatch |

## Verification
A wrong byte counter shows up within a single frame. The end marker lands on the wrong byte, and the status pulse comes one or more bytes early or late against the frame's last byte. A CRC register that is not cleared or not preset correctly flags errors on clean frames, or passes corrupted ones, at the second CRC byte of that frame. A parser state that is stuck or skipped shows at the next frame boundary: `in_ready` drops outside the data field, a header pulse goes missing, or stray data bytes appear after a header error.

// File: rtl/dmsg_pkg.sv
package dmsg_pkg;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_DATA  = 2'd1,
        CLS_CTRL  = 2'd2,
        CLS_MAINT = 2'd3
    } dmsg_class_e;

    typedef enum logic [3:0] {
        ST_HUNT,
        ST_SYN1,
        ST_SYN2,
        ST_HDR,
        ST_HCRC_LO,
        ST_HCRC_HI,
        ST_DATA,
        ST_DCRC_LO,
        ST_DCRC_HI
    } dmsg_state_e;

endpackage

// File: rtl/dmsg_crc16.sv
module dmsg_crc16 #(
    parameter int                 CRC_W = 16,
    parameter logic [CRC_W-1:0]   POLY  = 16'h1021
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic [7:0]       byte_in,
    output logic [CRC_W-1:0] crc_out
);
    logic [CRC_W-1:0] acc;
    logic             fb;

    // one byte, most significant bit first
    always_comb begin
        acc = crc_in;
        fb  = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            fb  = acc[CRC_W-1] ^ byte_in[i];
            acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
        crc_out = acc;
    end
endmodule

// File: rtl/dmsg_class_dec.sv
module dmsg_class_dec
    import dmsg_pkg::*;
#(
    parameter logic [7:0] DATA_CODE  = 8'h81,
    parameter logic [7:0] CTRL_CODE  = 8'h05,
    parameter logic [7:0] MAINT_CODE = 8'h90
) (
    input  logic [7:0]  code_in,
    output dmsg_class_e cls_out
);
    always_comb begin
        unique case (code_in)
            DATA_CODE:  cls_out = CLS_DATA;
            CTRL_CODE:  cls_out = CLS_CTRL;
            MAINT_CODE: cls_out = CLS_MAINT;
            default:    cls_out = CLS_NONE;
        endcase
    end
endmodule

// File: rtl/dmsg_rx.sv
module dmsg_rx
    import dmsg_pkg::*;
#(
    parameter logic [7:0]  SYNC_CODE  = 8'h96,
    parameter logic [7:0]  DATA_CODE  = 8'h81,
    parameter logic [7:0]  CTRL_CODE  = 8'h05,
    parameter logic [7:0]  MAINT_CODE = 8'h90,
    parameter int          CNT_W      = 14,
    parameter int          CRC_W      = 16,
    parameter logic [15:0] CRC_POLY   = 16'h1021
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    output logic        in_ready,
    output logic        dout_valid,
    output logic [7:0]  dout_data,
    output logic        dout_sop,
    output logic        dout_eop,
    input  logic        dout_ready,
    output logic        hdr_valid,
    output logic [1:0]  hdr_class,
    output logic [15:0] hdr_lead,
    output logic [7:0]  hdr_mid0,
    output logic [7:0]  hdr_mid1,
    output logic [7:0]  hdr_addr,
    output logic        stat_valid,
    output logic [1:0]  stat_class,
    output logic        stat_hdr_err,
    output logic        stat_data_err
);
    localparam logic [2:0] HDR_LAST = 3'd4;   // five header bytes, index 0..4

    typedef struct packed {
        dmsg_state_e        st;
        dmsg_class_e        cls;
        logic [2:0]         idx;
        logic [15:0]        lead;
        logic [7:0]         mid0;
        logic [7:0]         mid1;
        logic [7:0]         addr;
        logic [CRC_W-1:0]   crc;
        logic [7:0]         crc_lo;
        logic [CNT_W-1:0]   left;
        logic               hdr_v;
        logic               stat_v;
        dmsg_class_e        stat_cls;
        logic               stat_herr;
        logic               stat_derr;
    } regs_t;

    regs_t r_q, r_d;

    logic             take;
    logic [CRC_W-1:0] crc_seed;
    logic [CRC_W-1:0] crc_next;
    logic [CRC_W-1:0] crc_rx;
    dmsg_class_e      cls_dec;
    logic             in_data_ph;

    dmsg_crc16 #(.CRC_W(CRC_W), .POLY(CRC_POLY[CRC_W-1:0])) u_crc (
        .crc_in  (crc_seed),
        .byte_in (in_data),
        .crc_out (crc_next)
    );

    dmsg_class_dec #(
        .DATA_CODE  (DATA_CODE),
        .CTRL_CODE  (CTRL_CODE),
        .MAINT_CODE (MAINT_CODE)
    ) u_dec (
        .code_in (in_data),
        .cls_out (cls_dec)
    );

    assign in_data_ph = (r_q.st == ST_DATA);
    assign in_ready   = !in_data_ph || dout_ready;
    assign take       = in_valid && in_ready;
    assign crc_seed   = (r_q.st == ST_SYN2) ? '0 : r_q.crc;
    assign crc_rx     = {in_data, r_q.crc_lo};

    always_comb begin
        r_d        = r_q;
        r_d.hdr_v  = 1'b0;
        r_d.stat_v = 1'b0;
        if (take) begin
            unique case (r_q.st)
                ST_HUNT: begin
                    if (in_data == SYNC_CODE) r_d.st = ST_SYN1;
                end
                ST_SYN1: begin
                    r_d.st = (in_data == SYNC_CODE) ? ST_SYN2 : ST_HUNT;
                end
                ST_SYN2: begin
                    if (cls_dec != CLS_NONE) begin
                        r_d.cls = cls_dec;
                        r_d.crc = crc_next;
                        r_d.idx = '0;
                        r_d.st  = ST_HDR;
                    end else if (in_data != SYNC_CODE) begin
                        r_d.st = ST_HUNT;
                    end
                end
                ST_HDR: begin
                    r_d.crc = crc_next;
                    r_d.idx = r_q.idx + 3'd1;
                    unique case (r_q.idx)
                        3'd0:    r_d.lead[7:0]  = in_data;
                        3'd1:    r_d.lead[15:8] = in_data;
                        3'd2:    r_d.mid0       = in_data;
                        3'd3:    r_d.mid1       = in_data;
                        default: r_d.addr       = in_data;
                    endcase
                    if (r_q.idx == HDR_LAST) r_d.st = ST_HCRC_LO;
                end
                ST_HCRC_LO: begin
                    r_d.crc_lo = in_data;
                    r_d.st     = ST_HCRC_HI;
                end
                ST_HCRC_HI: begin
                    r_d.crc       = '0;
                    r_d.stat_cls  = r_q.cls;
                    r_d.stat_herr = 1'b0;
                    r_d.stat_derr = 1'b0;
                    r_d.st        = ST_HUNT;
                    if (r_q.crc != crc_rx) begin
                        r_d.stat_v    = 1'b1;
                        r_d.stat_herr = 1'b1;
                    end else begin
                        r_d.hdr_v = 1'b1;
                        if (r_q.cls == CLS_CTRL || r_q.lead[CNT_W-1:0] == '0) begin
                            r_d.stat_v = 1'b1;
                        end else begin
                            r_d.left = r_q.lead[CNT_W-1:0];
                            r_d.st   = ST_DATA;
                        end
                    end
                end
                ST_DATA: begin
                    r_d.crc  = crc_next;
                    r_d.left = r_q.left - 1'b1;
                    if (r_q.left == CNT_W'(1)) r_d.st = ST_DCRC_LO;
                end
                ST_DCRC_LO: begin
                    r_d.crc_lo = in_data;
                    r_d.st     = ST_DCRC_HI;
                end
                ST_DCRC_HI: begin
                    r_d.stat_v    = 1'b1;
                    r_d.stat_derr = (r_q.crc != crc_rx);
                    r_d.st        = ST_HUNT;
                end
                default: r_d.st = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dout_valid    = in_valid && in_data_ph;
    assign dout_data     = in_data;
    assign dout_sop      = in_data_ph && (r_q.left == r_q.lead[CNT_W-1:0]);
    assign dout_eop      = in_data_ph && (r_q.left == CNT_W'(1));
    assign hdr_valid     = r_q.hdr_v;
    assign hdr_class     = r_q.cls;
    assign hdr_lead      = r_q.lead;
    assign hdr_mid0      = r_q.mid0;
    assign hdr_mid1      = r_q.mid1;
    assign hdr_addr      = r_q.addr;
    assign stat_valid    = r_q.stat_v;
    assign stat_class    = r_q.stat_cls;
    assign stat_hdr_err  = r_q.stat_herr;
    assign stat_data_err = r_q.stat_derr;

    // a good header is never reported together with a header error
    assert_hdr_excl_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> !(stat_valid && stat_hdr_err));

    // control frames finish with their header
    assert_ctrl_ends_hdr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && stat_class == CLS_CTRL && !stat_hdr_err) |-> hdr_valid);

    // a data error only for frames that had a data field
    assert_derr_class_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && stat_data_err) |-> (stat_class != CLS_CTRL && !stat_hdr_err));

    // after the last data byte the CRC bytes follow, not more data
    assert_eop_then_crc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_valid && dout_ready && dout_eop) |=> !dout_valid);

    // start marker only once per data field
    assert_sop_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_valid && dout_ready && dout_sop && !dout_eop) |=> !dout_sop);

    // stalls happen only on offered data bytes
    assert_stall_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && in_valid) |-> dout_valid);

    // after a status pulse the receiver is hunting
    assert_hunt_after_stat_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> !dout_valid);

endmodule

// File: tb/dmsg_rx_test.sv
module dmsg_rx_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready;
    logic        dout_valid;
    logic [7:0]  dout_data;
    logic        dout_sop;
    logic        dout_eop;
    logic        dout_ready = 1'b1;
    logic        hdr_valid;
    logic [1:0]  hdr_class;
    logic [15:0] hdr_lead;
    logic [7:0]  hdr_mid0, hdr_mid1, hdr_addr;
    logic        stat_valid;
    logic [1:0]  stat_class;
    logic        stat_hdr_err, stat_data_err;

    localparam logic [7:0] SYN = 8'h96;
    localparam logic [7:0] CODE_DATA  = 8'h81;
    localparam logic [7:0] CODE_CTRL  = 8'h05;
    localparam logic [7:0] CODE_MAINT = 8'h90;

    always #4 clk = ~clk;   // 125 MHz

    dmsg_rx uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .dout_valid(dout_valid), .dout_data(dout_data),
        .dout_sop(dout_sop), .dout_eop(dout_eop), .dout_ready(dout_ready),
        .hdr_valid(hdr_valid), .hdr_class(hdr_class), .hdr_lead(hdr_lead),
        .hdr_mid0(hdr_mid0), .hdr_mid1(hdr_mid1), .hdr_addr(hdr_addr),
        .stat_valid(stat_valid), .stat_class(stat_class),
        .stat_hdr_err(stat_hdr_err), .stat_data_err(stat_data_err)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    logic [7:0] frm [0:127];
    int         frm_len;
    logic [7:0] obs_d [0:127];
    bit         obs_s [0:127];
    bit         obs_e [0:127];
    int         n_obs;
    int         cur_idx;
    int         r10_bad;
    int         hdr_cnt, hdr_at, stat_cnt, stat_at;
    logic [1:0]  h_cls, s_cls;
    logic [15:0] h_lead;
    logic [7:0]  h_m0, h_m1, h_ad;
    bit          s_herr, s_derr;

    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] x = c;
        for (int i = 7; i >= 0; i--) begin
            if (x[15] ^ d[i]) x = {x[14:0], 1'b0} ^ 16'h1021;
            else              x = {x[14:0], 1'b0};
        end
        return x;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_obs();
        n_obs = 0; cur_idx = 0; r10_bad = 0;
        hdr_cnt = 0; hdr_at = -1; stat_cnt = 0; stat_at = -1;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit data_ph);
        bit acc;
        do begin
            @(negedge clk);
            in_valid   = 1'b1;
            in_data    = b;
            dout_ready = ($urandom % 10) < 7;
            #1;
            if (in_ready !== (!data_ph || dout_ready)) r10_bad++;
            if (!data_ph && dout_valid) r10_bad++;
            acc = in_ready;
            if (dout_valid && dout_ready && n_obs < 128) begin
                obs_d[n_obs] = dout_data;
                obs_s[n_obs] = dout_sop;
                obs_e[n_obs] = dout_eop;
                n_obs++;
            end
            @(posedge clk); #1;
            if (hdr_valid) begin
                hdr_cnt++; hdr_at = cur_idx;
                h_cls = hdr_class; h_lead = hdr_lead;
                h_m0 = hdr_mid0; h_m1 = hdr_mid1; h_ad = hdr_addr;
            end
            if (stat_valid) begin
                stat_cnt++; stat_at = cur_idx;
                s_cls = stat_class; s_herr = stat_hdr_err; s_derr = stat_data_err;
            end
        end while (!acc);
        cur_idx++;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk); #1;
        if (hdr_valid) hdr_cnt++;
        if (stat_valid) stat_cnt++;
    endtask

    // cls: 1 data, 2 control, 3 maintenance; pat 1 fills data with sync/class codes
    task automatic run_frame(input int cls, input logic [15:0] lead_in, input int n,
                             input bit bad_h, input bit bad_d, input int nsyn, input int pat);
        logic [15:0] lead = lead_in;
        logic [15:0] c = 16'h0;
        logic [7:0]  code;
        int          p = 0;
        int          hdr_pos, n_exp, last_exp;
        bit          has_data;
        code = (cls == 1) ? CODE_DATA : (cls == 2) ? CODE_CTRL : CODE_MAINT;
        if (cls != 2) lead[13:0] = 14'(n);
        for (int i = 0; i < nsyn; i++) begin frm[p] = SYN; p++; end
        frm[p] = code; p++;
        frm[p] = lead[7:0]; p++;
        frm[p] = lead[15:8]; p++;
        frm[p] = 8'($urandom); p++;
        frm[p] = 8'($urandom); p++;
        frm[p] = 8'($urandom); p++;
        for (int i = p - 6; i < p; i++) c = crc_byte(c, frm[i]);
        c[0] = c[0] ^ bad_h;
        frm[p] = c[7:0]; p++;
        frm[p] = c[15:8]; p++;
        hdr_pos  = p - 1;
        has_data = !bad_h && cls != 2 && n > 0;
        n_exp    = has_data ? n : 0;
        if (has_data) begin
            c = 16'h0;
            for (int i = 0; i < n; i++) begin
                frm[p] = (pat == 1) ? ((i % 2) ? CODE_DATA : SYN) : 8'($urandom);
                c = crc_byte(c, frm[p]);
                p++;
            end
            c[3] = c[3] ^ bad_d;
            frm[p] = c[7:0]; p++;
            frm[p] = c[15:8]; p++;
        end
        frm_len  = p;
        last_exp = p - 1;
        clear_obs();
        for (int i = 0; i < frm_len; i++)
            send_byte(frm[i], has_data && i > hdr_pos && i <= hdr_pos + n);
        idle();
        // header reporting
        check(hdr_cnt == (bad_h ? 0 : 1), "R5 header pulse count", hdr_cnt, bad_h ? 0 : 1);
        if (!bad_h) begin
            check(hdr_at == hdr_pos, "R4 header pulse timing", hdr_at, hdr_pos);
            check(h_cls == 2'(cls), "R3 header class", h_cls, cls);
            check(h_lead == lead, "R4 lead field", h_lead, lead);
            check(h_m0 == frm[hdr_pos-4] && h_m1 == frm[hdr_pos-3] && h_ad == frm[hdr_pos-2],
                  "R4 mid/addr fields", {h_m0, h_m1, h_ad},
                  {frm[hdr_pos-4], frm[hdr_pos-3], frm[hdr_pos-2]});
        end
        // status
        check(stat_cnt == 1, "R11 status pulse count", stat_cnt, 1);
        check(stat_at == last_exp, (cls == 2) ? "R8 status timing" :
              (n == 0 && !bad_h) ? "R9 status timing" : "R7 status timing", stat_at, last_exp);
        check(s_cls == 2'(cls), "R3 status class", s_cls, cls);
        check(s_herr == bad_h, "R5 header error flag", s_herr, bad_h);
        check(s_derr == (has_data && bad_d), "R7 data error flag", s_derr, has_data && bad_d);
        // data field
        check(n_obs == n_exp, "R6 data byte count", n_obs, n_exp);
        for (int i = 0; i < n_obs && i < n_exp; i++) begin
            if (obs_d[i] != frm[hdr_pos+1+i] || obs_s[i] != (i == 0) || obs_e[i] != (i == n_exp-1)) begin
                check(0, "R6 data byte/markers", {obs_d[i], 7'd0, obs_s[i], 7'd0, obs_e[i]},
                      {frm[hdr_pos+1+i], 7'd0, 1'(i == 0), 7'd0, 1'(i == n_exp-1)});
                break;
            end
        end
        check(r10_bad == 0, "R10 ready/valid gating", r10_bad, 0);
    endtask

    initial begin
        int rnd_cls;
        void'($urandom(32'h5EED_0C3A));
        clear_obs();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check(in_ready == 1'b1, "R1 reset in_ready", in_ready, 1);
        check(!hdr_valid && !stat_valid && !dout_valid, "R1 reset outputs",
              {hdr_valid, stat_valid, dout_valid}, 0);

        // R2/R3: noise, single sync, unknown class code
        clear_obs();
        for (int i = 0; i < 20; i++) begin
            logic [7:0] b = 8'($urandom);
            if (b == SYN) b = 8'h00;
            send_byte(b, 0);
        end
        send_byte(SYN, 0); send_byte(CODE_DATA, 0);
        for (int i = 0; i < 8; i++) send_byte(8'h11, 0);
        send_byte(SYN, 0); send_byte(SYN, 0); send_byte(8'h42, 0);
        for (int i = 0; i < 8; i++) send_byte(8'h22, 0);
        idle();
        check(hdr_cnt == 0 && stat_cnt == 0, "R2 single sync / noise ignored", hdr_cnt + stat_cnt, 0);
        check(n_obs == 0, "R3 unknown class gives no data", n_obs, 0);
        check(r10_bad == 0, "R10 ready outside data", r10_bad, 0);

        // directed frames
        run_frame(1, 16'hC000, 5, 0, 0, 2, 0);    // R6 flags set
        run_frame(3, 16'h0000, 6, 0, 0, 4, 1);    // R2 extra sync, R6 code bytes as data
        run_frame(2, 16'h3FFF, 0, 0, 0, 2, 0);    // R8 control, lead looks like a count
        run_frame(1, 16'h0000, 0, 0, 0, 2, 0);    // R9 zero count
        run_frame(3, 16'h4000, 0, 0, 0, 2, 0);    // R9 maintenance zero count
        run_frame(1, 16'h0000, 9, 1, 0, 2, 0);    // R5 header error
        run_frame(1, 16'h0000, 7, 0, 1, 2, 0);    // R7 data error
        run_frame(3, 16'h8000, 1, 0, 0, 2, 0);    // R6 single byte

        // constrained random frames, back to back (R11)
        for (int k = 0; k < 40; k++) begin
            rnd_cls = 1 + ($urandom % 3);
            run_frame(rnd_cls, 16'($urandom), ($urandom % 5 == 0) ? 0 : 1 + ($urandom % 40),
                      ($urandom % 8) == 0, ($urandom % 6) == 0, 2 + ($urandom % 2), 0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule